// File: doc/BRIEF.md
# I2C Slave Byte Receiver with Clock Stretching

This block is the receive side of a 7-bit-addressed I2C target. It watches the two bus lines through synchronizers clocked by the system clock. After every start condition it treats the first byte as an address plus direction bit. If the address matches `own_addr` and the direction is write, the block acknowledges. It then hands every byte that follows to software through a one-byte receive register and a full flag.

The lines are only ever pulled low (open-drain) and are released otherwise. Software sets the acknowledge level it wants through `ack_bit` and collects bytes by pulsing `rd_en`. The address byte itself also lands in the receive register, and software discards it with one read. When software has not yet collected the previous byte, the block holds SCL low after the eighth bit of the next byte. The master then waits until `rd_en` frees the register.

Top module: `i2c_slave_rx`

## Requirements
- R1: While `en` is 0 the block pulls neither line low, keeps `rx_full` at 0 and ignores all bus traffic.
- R2: When the first byte after a start has bits 7:1 equal to `own_addr` and bit 0 equal to 0 (write), the block acknowledges in the 9th clock. It also loads that byte into `rx_data` and sets `rx_full` at the 9th rising SCL edge.
- R3: When the first byte after a start carries a different address, or bit 0 equal to 1, SDA stays released in the 9th clock and `rx_full` stays 0. Every further byte is then ignored until the next start.
- R4: After an address match, each data byte is taken MSB first on SCL rising edges. It is loaded into `rx_data`, and `rx_full` is set at the 9th rising edge.
- R5: A one-cycle pulse on `rd_en` clears `rx_full`.
- R6: If `rx_full` is 1 when the 8th falling SCL edge of an acknowledged frame arrives, SCL is held low until `rd_en` is pulsed. It is released within a few cycles of that pulse.
- R7: The acknowledge level is the value of `ack_bit` at the 8th falling SCL edge: 0 pulls SDA low (acknowledge) and 1 leaves it released. A change made later, while SCL is being stretched, takes effect only in the next frame.
- R8: A stop condition (SDA rising while SCL is high) returns the block to idle, so bytes clocked afterwards without a start are ignored. A start condition (SDA falling while SCL is high) restarts the address phase at bit 0, even in the middle of a byte.
- R9: SDA is released again after the falling SCL edge that ends the acknowledge clock, and SDA is only changed while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| own_addr | input | 7 | Programmed 7-bit slave address |
| ack_bit | input | 1 | Acknowledge level: 0 acknowledges, 1 does not |
| rd_en | input | 1 | Read strobe for the receive register, clears the full flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretching) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | 8 | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |

## Verification
The hardest situation to reach is a change of `ack_bit` that lands inside a stretch. It needs an unread byte, a master that has already finished the eighth bit of the next byte, and a read that comes only after the new acknowledge level is written. The bench gets there by deliberately leaving the address byte unread and clocking a full data byte. It then sees SCL held low on the line model, flips `ack_bit`, and only afterwards pulses `rd_en`. The acknowledge observed in that frame and in the following frame shows which `ack_bit` value each one used.

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_bit,
  input  logic              rd_en,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic [ADDR_W:0]   rx_data,
  output logic              rx_full
);
  localparam int BW = ADDR_W + 1;

  typedef enum logic [1:0] {IDLE, ADDR, DATA, SKIP} st_t;

  logic scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [BW-1:0] shreg;
  logic acking, ack_q, hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= '1;
    else begin
      {scl_q, scl_s, scl_m} <= {scl_s, scl_m, scl_i};
      {sda_q, sda_s, sda_m} <= {sda_s, sda_m, sda_i};
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_ok  = (shreg[BW-1:1] == own_addr) & ~shreg[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; shreg <= '0; acking <= 1'b0;
      ack_q <= 1'b0; hold <= 1'b0; rx_data <= '0; rx_full <= 1'b0;
    end else if (!en) begin
      st <= IDLE; cnt <= '0; acking <= 1'b0; hold <= 1'b0; rx_full <= 1'b0;
    end else begin
      if (rd_en) begin
        rx_full <= 1'b0;
        hold    <= 1'b0;
      end
      if (stop_c) begin
        st <= IDLE; cnt <= '0; acking <= 1'b0; hold <= 1'b0;
      end else if (start_c) begin
        st <= ADDR; cnt <= '0; acking <= 1'b0;
      end else if (st == ADDR || st == DATA) begin
        if (scl_rise) begin
          if (cnt < 4'(BW)) shreg <= {shreg[BW-2:0], sda_s};
          cnt <= cnt + 4'd1;
          if (cnt == 4'(BW) && acking) begin
            rx_data <= shreg;
            rx_full <= 1'b1;
            st      <= DATA;
          end
        end
        if (scl_fall) begin
          if (cnt == 4'(BW)) begin
            if (st == DATA || addr_ok) begin
              acking <= 1'b1;
              ack_q  <= ack_bit;
              hold   <= rx_full & ~rd_en;
            end else st <= SKIP;
          end
          if (cnt == 4'(BW + 1)) begin
            acking <= 1'b0;
            cnt    <= '0;
          end
        end
      end
    end

  assign scl_drive_low = en & hold;
  assign sda_drive_low = en & acking & ~ack_q;
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       rd_en,
  input logic       scl_s,
  input logic [1:0] st,
  input logic       rx_full,
  input logic       scl_drive_low,
  input logic       sda_drive_low
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rx_full && !scl_drive_low && !sda_drive_low);

  a_r5_read_frees_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_en && rx_full && scl_drive_low) |=> !rx_full && !scl_drive_low);

  a_r6_stretch_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> rx_full);

  a_r3_silent_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3) |-> !sda_drive_low);

  a_r9_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n || !en)
    !$stable(sda_drive_low) |-> !scl_s);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rd_en(rd_en), .scl_s(scl_s), .st(st),
  .rx_full(rx_full), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/sim_i2c_slave_rx.sv
module sim_i2c_slave_rx;
  localparam int H = 10;
  localparam logic [6:0] ADR = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ack_bit = 1'b0, rd_en = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_dl, sda_dl, rx_full, scl, sda;
  logic [7:0] rx_data;
  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;
  assign scl = m_scl & ~scl_dl;
  assign sda = m_sda & ~sda_dl;

  i2c_slave_rx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(ADR), .ack_bit(ack_bit),
    .rd_en(rd_en), .scl_i(scl), .sda_i(sda), .scl_drive_low(scl_dl),
    .sda_drive_low(sda_dl), .rx_data(rx_data), .rx_full(rx_full)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    int t = 0;
    m_scl = 1'b1;
    while (!scl && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; idle(H); scl_up(); idle(H);
    m_sda = 1'b0; idle(H); m_scl = 1'b0; idle(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(H); scl_up(); idle(H); m_sda = 1'b1; idle(H);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; idle(H); scl_up(); idle(H); s = sda; m_scl = 1'b0; idle(H);
  endtask

  task automatic send8(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
  endtask

  task automatic ack_clk(output logic acked);
    logic s;
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic xfer(input logic [7:0] v, output logic acked);
    send8(v); ack_clk(acked);
  endtask

  task automatic rd_pulse();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(!scl_dl && !sda_dl, "R1 reset lines", {scl_dl, sda_dl}, 0);
    chk(!rx_full, "R1 reset full", rx_full, 0);
  endtask

  task automatic t_disabled();
    logic a;
    en = 1'b0;
    bus_start(); xfer({ADR, 1'b0}, a);
    chk(!a, "R1 no ack when off", a, 0);
    chk(!rx_full, "R1 full stays 0", rx_full, 0);
    bus_stop();
    en = 1'b1; idle(4);
  endtask

  task automatic t_write();
    logic a;
    ack_bit = 1'b0;
    bus_start(); xfer({ADR, 1'b0}, a);
    chk(a, "R2 address ack", a, 1);
    chk(rx_full && rx_data == {ADR, 1'b0}, "R2 address byte", rx_data, {ADR, 1'b0});
    chk(!sda_dl, "R9 sda released", sda_dl, 0);
    rd_pulse();
    chk(!rx_full, "R5 read clears", rx_full, 0);
    xfer(8'hA5, a);
    chk(a && rx_full && rx_data == 8'hA5, "R4 byte A5", rx_data, 8'hA5);
    chk(!sda_dl, "R9 release after data", sda_dl, 0);
    rd_pulse();
    xfer(8'h3C, a);
    chk(a && rx_data == 8'h3C, "R4 byte 3C", rx_data, 8'h3C);
    rd_pulse();
    chk(!scl_dl, "R6 no stretch when read in time", scl_dl, 0);
    bus_stop();
  endtask

  task automatic t_nomatch();
    logic a;
    bus_start(); xfer({ADR ^ 7'h01, 1'b0}, a);
    chk(!a && !rx_full, "R3 wrong address", {a, rx_full}, 0);
    xfer(8'h00, a);
    chk(!a && !rx_full, "R3 later byte ignored", {a, rx_full}, 0);
    bus_stop();
    bus_start(); xfer({ADR, 1'b1}, a);
    chk(!a && !rx_full, "R3 read direction", {a, rx_full}, 0);
    bus_stop();
  endtask

  task automatic t_stretch();
    logic a;
    ack_bit = 1'b0;
    bus_start(); xfer({ADR, 1'b0}, a);
    send8(8'h5A);
    chk(scl_dl, "R6 stretch starts", scl_dl, 1);
    idle(40);
    chk(scl_dl && !scl, "R6 stretch held", scl, 0);
    ack_bit = 1'b1;
    chk(rx_data == {ADR, 1'b0}, "R6 pending byte", rx_data, {ADR, 1'b0});
    rd_pulse(); idle(3);
    chk(!scl_dl, "R6 stretch released", scl_dl, 0);
    ack_clk(a);
    chk(a, "R7 old ack level kept", a, 1);
    chk(rx_data == 8'h5A, "R4 stretched byte", rx_data, 8'h5A);
    rd_pulse();
    xfer(8'hC3, a);
    chk(!a, "R7 new level next frame", a, 0);
    chk(rx_full && rx_data == 8'hC3, "R4 byte under nack", rx_data, 8'hC3);
    rd_pulse();
    ack_bit = 1'b0;
    bus_stop();
  endtask

  task automatic t_stop_restart();
    logic a, s;
    xfer({ADR, 1'b0}, a);
    chk(!a && !rx_full, "R8 ignored after stop", {a, rx_full}, 0);
    bus_start();
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    bus_start();
    xfer({ADR, 1'b0}, a);
    chk(a && rx_data == {ADR, 1'b0}, "R8 repeated start", rx_data, {ADR, 1'b0});
    rd_pulse();
    bus_stop();
  endtask

  initial begin
    idle(5); rst_n = 1'b1; idle(5);
    t_reset();
    t_disabled();
    t_write();
    t_nomatch();
    t_stretch();
    t_stop_restart();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule